// File: doc/BRIEF.md
# Arbitrating 2x2 Routing Switch

This block is one switching element of a multistage processor-to-memory network. It has two inputs, A and B. Each input carries a valid flag, a data word and one routing bit that selects the upper or the lower output. In each cycle the element connects every valid input to the output it asks for. Two inputs that ask for different outputs both pass in the same cycle.

When both valid inputs ask for the same output, the element lets only one of them through. It raises a combinational blocked flag for the other input in that same cycle, so the source can present the word again on the next cycle. A single priority bit decides who wins. It flips after every conflict, so the two inputs take turns winning and neither can be starved. Both outputs are registered and carry a valid flag. Each output shows the winning word one cycle after it was presented.

Top module: `sw2x2_router`

## Requirements
- R1: After reset both output valid flags are low, both blocked flags are low while the inputs are idle, and the first conflict after reset is won by input A.
- R2: A valid, unblocked input A with routing bit 0 appears on the upper output one cycle later, and with routing bit 1 on the lower output, with its data unchanged.
- R3: Input B follows the same rule as A, using its own routing bit.
- R4: When both inputs are valid and ask for different outputs, both words appear on their outputs in the same following cycle, and neither input is blocked.
- R5: When both inputs are valid and ask for the same output, exactly one word reaches that output in the next cycle, the other output stays invalid, and the losing input's blocked flag is high in the cycle it was presented.
- R6: The winner of conflicts alternates: after each conflict the other input wins the next conflict. Cycles without a conflict leave the order unchanged.
- R7: An input whose valid flag is low claims no output, whatever its routing bit and data, and it never causes the other input to be blocked.
- R8: A blocked flag is high only in a cycle with a conflict, at most one blocked flag is high at a time, and an output that no input claimed has its valid flag low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_vld_i | input | 1 | Input A word present |
| a_dst_i | input | 1 | Input A route: 0 upper, 1 lower |
| a_dat_i | input | DATA_W | Input A data |
| b_vld_i | input | 1 | Input B word present |
| b_dst_i | input | 1 | Input B route: 0 upper, 1 lower |
| b_dat_i | input | DATA_W | Input B data |
| a_blk_o | output | 1 | Input A lost a conflict this cycle |
| b_blk_o | output | 1 | Input B lost a conflict this cycle |
| up_vld_o | output | 1 | Upper output valid (registered) |
| up_dat_o | output | DATA_W | Upper output data (registered) |
| dn_vld_o | output | 1 | Lower output valid (registered) |
| dn_dat_o | output | DATA_W | Lower output data (registered) |

## Verification
The bench steps through all sixteen combinations of the two valid flags and the two routing bits, and it runs that sweep several times. Each input uses its own data pattern, so a swapped or wrongly routed word shows up on the data lines. The runs with only one valid input separate A's routing from B's. The crossing and parallel patterns show that both words pass in one cycle. The two same-output patterns cover the upper and the lower side. The bench also applies runs of conflicts back to back and with quiet cycles in between. These separate a priority bit that flips once per conflict from one that flips every cycle or never flips. The patterns with an idle input use routing bits and data that would cause a conflict if they were honoured.

// File: rtl/sw2x2_pkg.sv
package sw2x2_pkg;
  localparam int unsigned NUM_PORTS = 2;
  typedef enum logic {
    PORT_UP = 1'b0,
    PORT_DN = 1'b1
  } port_e;
endpackage

// File: rtl/sw2x2_req.sv
module sw2x2_req
  import sw2x2_pkg::*;
(
  input  logic                 vld_i,
  input  logic                 dst_i,
  output logic [NUM_PORTS-1:0] req_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
    assign req_o[p] = vld_i && (dst_i == p[0]);
  end
endmodule

// File: rtl/sw2x2_arb.sv
module sw2x2_arb
  import sw2x2_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] a_req_i,
  input  logic [NUM_PORTS-1:0] b_req_i,
  output logic [NUM_PORTS-1:0] a_gnt_o,
  output logic [NUM_PORTS-1:0] b_gnt_o,
  output logic                 a_blk_o,
  output logic                 b_blk_o
);
  logic clash;
  logic favor_b_q;  // 0: A wins the next conflict

  assign clash   = |(a_req_i & b_req_i);
  assign a_blk_o = clash && favor_b_q;
  assign b_blk_o = clash && !favor_b_q;
  assign a_gnt_o = a_blk_o ? '0 : a_req_i;
  assign b_gnt_o = b_blk_o ? '0 : b_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) favor_b_q <= 1'b0;
    else if (clash) favor_b_q <= !favor_b_q;
  end

  assert_prio_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash |=> (favor_b_q != $past(favor_b_q)));
  assert_prio_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clash |=> $stable(favor_b_q));
  assert_gnt_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_gnt_o & b_gnt_o) == '0);
endmodule

// File: rtl/sw2x2_out.sv
module sw2x2_out #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_a_i,
  input  logic              take_b_i,
  input  logic [DATA_W-1:0] a_dat_i,
  input  logic [DATA_W-1:0] b_dat_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= take_a_i || take_b_i;
      if (take_a_i)      dat_o <= a_dat_i;
      else if (take_b_i) dat_o <= b_dat_i;
    end
  end

  assert_one_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_a_i && take_b_i));
endmodule

// File: rtl/sw2x2_router.sv
module sw2x2_router
  import sw2x2_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_vld_i,
  input  logic              a_dst_i,
  input  logic [DATA_W-1:0] a_dat_i,
  input  logic              b_vld_i,
  input  logic              b_dst_i,
  input  logic [DATA_W-1:0] b_dat_i,
  output logic              a_blk_o,
  output logic              b_blk_o,
  output logic              up_vld_o,
  output logic [DATA_W-1:0] up_dat_o,
  output logic              dn_vld_o,
  output logic [DATA_W-1:0] dn_dat_o
);
  logic [NUM_PORTS-1:0] a_req, b_req, a_gnt, b_gnt;
  logic [NUM_PORTS-1:0] o_vld;
  logic [DATA_W-1:0]    o_dat [NUM_PORTS];

  sw2x2_req u_req_a (.vld_i(a_vld_i), .dst_i(a_dst_i), .req_o(a_req));
  sw2x2_req u_req_b (.vld_i(b_vld_i), .dst_i(b_dst_i), .req_o(b_req));

  sw2x2_arb u_arb (
    .clk_i, .rst_ni,
    .a_req_i(a_req), .b_req_i(b_req),
    .a_gnt_o(a_gnt), .b_gnt_o(b_gnt),
    .a_blk_o, .b_blk_o
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    sw2x2_out #(.DATA_W(DATA_W)) u_out (
      .clk_i, .rst_ni,
      .take_a_i(a_gnt[p]), .take_b_i(b_gnt[p]),
      .a_dat_i, .b_dat_i,
      .vld_o(o_vld[p]), .dat_o(o_dat[p])
    );
  end

  assign up_vld_o = o_vld[PORT_UP];
  assign up_dat_o = o_dat[PORT_UP];
  assign dn_vld_o = o_vld[PORT_DN];
  assign dn_dat_o = o_dat[PORT_DN];

  assert_blk_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_blk_o && b_blk_o));
  assert_blk_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_blk_o || b_blk_o) |-> (a_vld_i && b_vld_i && a_dst_i == b_dst_i));
  assert_a_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_vld_i && !a_blk_o && !a_dst_i) |=> (up_vld_o && up_dat_o == $past(a_dat_i)));
  assert_b_route_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_vld_i && !b_blk_o && b_dst_i) |=> (dn_vld_o && dn_dat_o == $past(b_dat_i)));
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_vld_i && !b_vld_i) |=> (!up_vld_o && !dn_vld_o));
endmodule

// File: tb/tb_sw2x2_router.sv
module tb_sw2x2_router;
  localparam int DATA_W = 8;
  localparam int CLK_P  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_vld = 0, a_dst = 0, b_vld = 0, b_dst = 0;
  logic [DATA_W-1:0] a_dat = '0, b_dat = '0;
  logic a_blk, b_blk, up_vld, dn_vld;
  logic [DATA_W-1:0] up_dat, dn_dat;

  int total = 0;
  int bad = 0;
  logic m_favor_b = 1'b0;

  always #(CLK_P/2) clk = !clk;

  sw2x2_router #(.DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_vld_i(a_vld), .a_dst_i(a_dst), .a_dat_i(a_dat),
    .b_vld_i(b_vld), .b_dst_i(b_dst), .b_dat_i(b_dat),
    .a_blk_o(a_blk), .b_blk_o(b_blk),
    .up_vld_o(up_vld), .up_dat_o(up_dat),
    .dn_vld_o(dn_vld), .dn_dat_o(dn_dat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one vector: drive at negedge, check blocked flags, check outputs one cycle later
  task automatic step(input logic av, input logic ad, input logic bv, input logic bd,
                      input logic [DATA_W-1:0] adat, input logic [DATA_W-1:0] bdat);
    logic clash, a_win, b_win, e_up, e_dn;
    logic [DATA_W-1:0] e_upd, e_dnd;
    string tag;
    a_vld = av; a_dst = ad; a_dat = adat;
    b_vld = bv; b_dst = bd; b_dat = bdat;
    clash = av && bv && (ad == bd);
    a_win = av && (!clash || !m_favor_b);
    b_win = bv && (!clash || m_favor_b);
    e_up  = (a_win && !ad) || (b_win && !bd);
    e_dn  = (a_win && ad)  || (b_win && bd);
    e_upd = (a_win && !ad) ? adat : bdat;
    e_dnd = (a_win && ad)  ? adat : bdat;
    tag = clash ? "R5/R6" : ((av && bv) ? "R4" : ((!av || !bv) ? "R7/R8" : "R8"));
    #1;
    chk({tag, " a_blk"}, a_blk, clash && m_favor_b);
    chk({tag, " b_blk"}, b_blk, clash && !m_favor_b);
    @(negedge clk);
    chk(av && !bv ? "R2 up_vld" : (bv && !av ? "R3 up_vld" : {tag, " up_vld"}), up_vld, e_up);
    chk(av && !bv ? "R2 dn_vld" : (bv && !av ? "R3 dn_vld" : {tag, " dn_vld"}), dn_vld, e_dn);
    if (e_up) chk({tag, " up_dat"}, up_dat, e_upd);
    if (e_dn) chk({tag, " dn_dat"}, dn_dat, e_dnd);
    if (clash) m_favor_b = !m_favor_b;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 up_vld", up_vld, 1'b0);
    chk("R1 dn_vld", dn_vld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 a_blk idle", a_blk, 1'b0);
    chk("R1 b_blk idle", b_blk, 1'b0);
    chk("R1 up_vld after release", up_vld, 1'b0);
    // R1: first conflict after reset goes to A
    step(1, 0, 1, 0, 8'h11, 8'h22);
    // R6: next conflict goes to B, then A again (lower side)
    step(1, 1, 1, 1, 8'h33, 8'h44);
    step(1, 1, 1, 1, 8'h55, 8'h66);
    // R6: non-conflict cycles keep the order
    step(1, 0, 1, 1, 8'h77, 8'h88);
    step(0, 0, 0, 0, 8'h99, 8'hAA);
    step(1, 0, 1, 0, 8'hBB, 8'hCC);
    // exhaustive sweeps over valid flags and routing bits (R2-R8)
    for (int rep = 0; rep < 4; rep++) begin
      for (int v = 0; v < 16; v++) begin
        step(v[3], v[2], v[1], v[0],
             8'hA0 | 8'(v), 8'h50 | 8'(v) ^ 8'(rep));
      end
    end
    // R7: idle inputs with routing and data that would collide
    step(0, 1, 1, 1, 8'hDE, 8'hAD);
    step(1, 0, 0, 0, 8'hBE, 8'hEF);
    step(0, 0, 0, 0, 8'hFF, 8'hFF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule